// File: doc/BRIEF.md
# Prefix-Extended Byte Load Unit

This unit decodes and executes two instructions of a 16-bit instruction stream. The first is an address prefix that carries a 13-bit immediate. The second is a signed byte load from an absolute address. A load with no prefix in front of it reaches only the lowest 128 bytes. One prefix widens its address to 20 bits, and two prefixes widen it to 24 bits. The prefix state sits in a small register pair, which the next non-prefix instruction consumes and then clears.

When a load is presented, the memory address and the read strobe are driven combinationally in that same cycle. The returned byte is sign-extended to 16 bits, and the top byte is forced to zero. On the next clock edge the result is written to the register-file port, together with the destination index. A load that sits in a branch delay slot always uses the short 7-bit address form.

Top module: `xbl_unit`

## Requirements
- R1: A valid word whose bits 15:10 are 110000 is a load. Its destination index is in bits 9:7 and its unsigned address immediate is in bits 6:0. In the same cycle the unit asserts `mem_rd_o`.
- R2: A load with no pending prefix drives `mem_addr_o` with the 7-bit immediate, zero-extended to 24 bits.
- R3: The written data holds the loaded byte in bits 7:0. Bit 7 of that byte is copied into bits 15:8, and bits 23:16 are zero.
- R4: After one prefix with immediate P, the load address is P in bits 19:7, the load immediate in bits 6:0, and zero in bits 23:20. A prefix of 0x1 followed by an immediate of 0x1 reads 0x81.
- R5: After two prefixes P1 then P2, the load address is P1[4:0] in bits 23:19, P2 in bits 18:6 and immediate bits 5:0 in bits 5:0. Immediate bit 6 has no effect.
- R6: After three or more consecutive prefixes, only the two most recent ones shape the address, following the layout of R5.
- R7: A load with `delay_slot_i` high uses the form of R2 regardless of pending prefixes. The pending prefixes are discarded afterwards.
- R8: A valid word whose bits 15:13 are 111 is a prefix whose immediate is in bits 12:0. A prefix makes no read and no register write.
- R9: Any other valid word makes no read and no register write, and it discards pending prefixes.
- R10: While `insn_valid_i` is low, no read or write is made and the prefix state is held.
- R11: A synchronous active-high reset clears the prefix state and deasserts `rf_we_o`.
- R12: `rf_we_o` rises exactly one clock edge after the load cycle. `rf_idx_o` then carries the load's destination index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 16 | Instruction word |
| insn_valid_i | input | 1 | Instruction word is valid this cycle |
| delay_slot_i | input | 1 | Instruction sits in a branch delay slot |
| mem_rdata_i | input | 8 | Byte returned by memory for the current read |
| mem_addr_o | output | 24 | Byte read address |
| mem_rd_o | output | 1 | Read strobe |
| rf_we_o | output | 1 | Register write enable |
| rf_idx_o | output | 3 | Register write index |
| rf_wdata_o | output | 24 | Register write data |

## Verification
The prefix bookkeeping and the load's address formation both act in the cycle of a load. In that cycle the counter clears, while the address still has to be built from the old accumulator. A mismatch here shows up as a wrong wide address, or as a stale prefix leaking into the next load. The bench therefore places loads directly after one, two and three prefixes. It compares the strobed address against the layout computed from the prefix values, and then issues a bare load to confirm that the state was cleared. The delay-slot case is provoked the same way, with prefixes pending, and is judged by the short address and by the clean state that follows it.

// File: rtl/xbl_pkg.sv
package xbl_pkg;
  localparam int INSN_W = 16;
  localparam int PFX_W  = 13;
  localparam int IMM_W  = 7;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 24;
  localparam int BYTE_W = 8;
  localparam int SEXT_W = 16;
  localparam int IDX_W  = 3;
  // bits of the older prefix that survive in a two-prefix address
  localparam int HI_W   = ADDR_W - PFX_W - (IMM_W - 1);
  localparam int ACC_W  = HI_W + PFX_W;
  localparam logic [5:0] LD_OP  = 6'b110000;
  localparam logic [2:0] PFX_OP = 3'b111;

  typedef enum logic [1:0] {
    PF_NONE = 2'd0,
    PF_ONE  = 2'd1,
    PF_TWO  = 2'd2
  } pfx_cnt_t;
endpackage

// File: rtl/xbl_decode.sv
module xbl_decode
  import xbl_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  input  logic              valid,
  output logic              is_load,
  output logic              is_pfx,
  output logic              is_other,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [IMM_W-1:0]  imm7,
  output logic [PFX_W-1:0]  imm13
);
  always_comb begin
    is_load  = valid && (insn[INSN_W-1 -: 6] == LD_OP);
    is_pfx   = valid && (insn[INSN_W-1 -: 3] == PFX_OP);
    is_other = valid && !is_load && !is_pfx;
    rd_idx   = insn[IMM_W +: IDX_W];
    imm7     = insn[IMM_W-1:0];
    imm13    = insn[PFX_W-1:0];
  end
endmodule

// File: rtl/xbl_prefix_acc.sv
module xbl_prefix_acc
  import xbl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             is_pfx,
  input  logic             consume,
  input  logic [PFX_W-1:0] imm13,
  output pfx_cnt_t         cnt,
  output logic [ACC_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= PF_NONE;
      acc <= '0;
    end else if (is_pfx) begin
      // the newest prefix enters the low field, and the old low field moves up
      acc <= {acc[HI_W-1:0], imm13};
      cnt <= (cnt == PF_NONE) ? PF_ONE : PF_TWO;
    end else if (consume) begin
      acc <= '0;
      cnt <= PF_NONE;
    end
  end
endmodule

// File: rtl/xbl_addr_gen.sv
module xbl_addr_gen
  import xbl_pkg::*;
(
  input  pfx_cnt_t          cnt,
  input  logic              delay_slot,
  input  logic [ACC_W-1:0]  acc,
  input  logic [IMM_W-1:0]  imm7,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAD0_W = ADDR_W - IMM_W;
  localparam int PAD1_W = ADDR_W - PFX_W - IMM_W;

  always_comb begin
    if (delay_slot) begin
      addr = {{PAD0_W{1'b0}}, imm7};
    end else begin
      unique case (cnt)
        PF_ONE:  addr = {{PAD1_W{1'b0}}, acc[PFX_W-1:0], imm7};
        PF_TWO:  addr = {acc[ACC_W-1:PFX_W], acc[PFX_W-1:0], imm7[IMM_W-2:0]};
        default: addr = {{PAD0_W{1'b0}}, imm7};
      endcase
    end
  end
endmodule

// File: rtl/xbl_writeback.sv
module xbl_writeback
  import xbl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              is_load,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [BYTE_W-1:0] rdata,
  output logic              we,
  output logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      we    <= 1'b0;
      idx   <= '0;
      wdata <= '0;
    end else begin
      we <= is_load;
      if (is_load) begin
        idx   <= rd_idx;
        wdata <= {{(DATA_W-SEXT_W){1'b0}},
                  {(SEXT_W-BYTE_W){rdata[BYTE_W-1]}}, rdata};
      end
    end
  end
endmodule

// File: rtl/xbl_unit.sv
module xbl_unit
  import xbl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [INSN_W-1:0] insn_i,
  input  logic              insn_valid_i,
  input  logic              delay_slot_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              rf_we_o,
  output logic [IDX_W-1:0]  rf_idx_o,
  output logic [DATA_W-1:0] rf_wdata_o
);
  logic             is_load, is_pfx, is_other;
  logic [IDX_W-1:0] rd_idx;
  logic [IMM_W-1:0] imm7;
  logic [PFX_W-1:0] imm13;
  pfx_cnt_t         cnt;
  logic [ACC_W-1:0] acc;

  xbl_decode u_dec (
    .insn(insn_i), .valid(insn_valid_i), .is_load(is_load), .is_pfx(is_pfx),
    .is_other(is_other), .rd_idx(rd_idx), .imm7(imm7), .imm13(imm13)
  );

  xbl_prefix_acc u_pfx (
    .clk(clk), .rst(rst), .is_pfx(is_pfx), .consume(is_load || is_other),
    .imm13(imm13), .cnt(cnt), .acc(acc)
  );

  xbl_addr_gen u_agen (
    .cnt(cnt), .delay_slot(delay_slot_i), .acc(acc), .imm7(imm7),
    .addr(mem_addr_o)
  );

  xbl_writeback u_wb (
    .clk(clk), .rst(rst), .is_load(is_load), .rd_idx(rd_idx),
    .rdata(mem_rdata_i), .we(rf_we_o), .idx(rf_idx_o), .wdata(rf_wdata_o)
  );

  assign mem_rd_o = is_load;
endmodule

// File: rtl/xbl_unit_chk.sv
module xbl_unit_chk
  import xbl_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [INSN_W-1:0] insn_i,
  input logic              insn_valid_i,
  input logic              delay_slot_i,
  input logic [BYTE_W-1:0] mem_rdata_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rd_o,
  input logic              rf_we_o,
  input logic [IDX_W-1:0]  rf_idx_o,
  input logic [DATA_W-1:0] rf_wdata_o
);
  // R10
  rd_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_o |-> insn_valid_i);
  // R12
  we_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> $past(mem_rd_o));
  // R12
  idx_from_insn_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> rf_idx_o == $past(insn_i[IMM_W +: IDX_W]));
  // R3
  low_byte_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> rf_wdata_o[BYTE_W-1:0] == $past(mem_rdata_i));
  // R3
  sext_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> rf_wdata_o[SEXT_W-1:BYTE_W] == {(SEXT_W-BYTE_W){rf_wdata_o[BYTE_W-1]}});
  // R3
  top_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> rf_wdata_o[DATA_W-1:SEXT_W] == '0);
  // R7
  delay_short_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_o && delay_slot_i) |-> mem_addr_o[ADDR_W-1:IMM_W] == '0);
  // R11
  reset_we_chk: assert property (@(posedge clk)
    rst |=> !rf_we_o);
endmodule

bind xbl_unit xbl_unit_chk i_chk (
  .clk(clk), .rst(rst), .insn_i(insn_i), .insn_valid_i(insn_valid_i),
  .delay_slot_i(delay_slot_i), .mem_rdata_i(mem_rdata_i),
  .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .rf_we_o(rf_we_o),
  .rf_idx_o(rf_idx_o), .rf_wdata_o(rf_wdata_o)
);

// File: tb/test_xbl_unit.sv
module test_xbl_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] insn_i = '0;
  logic        insn_valid_i = 1'b0;
  logic        delay_slot_i = 1'b0;
  logic [7:0]  mem_rdata_i = '0;
  logic [23:0] mem_addr_o;
  logic        mem_rd_o;
  logic        rf_we_o;
  logic [2:0]  rf_idx_o;
  logic [23:0] rf_wdata_o;

  int nchecks = 0;
  int nerrs = 0;
  bit done = 1'b0;

  logic [23:0] s_addr;
  logic        s_rd;
  logic        s_we;
  logic [2:0]  s_idx;
  logic [23:0] s_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbl_unit i_xbl_unit (
    .clk(clk), .rst(rst), .insn_i(insn_i), .insn_valid_i(insn_valid_i),
    .delay_slot_i(delay_slot_i), .mem_rdata_i(mem_rdata_i),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .rf_we_o(rf_we_o),
    .rf_idx_o(rf_idx_o), .rf_wdata_o(rf_wdata_o)
  );

  function automatic logic [15:0] ld(input logic [2:0] idx, input logic [6:0] imm);
    return {6'b110000, idx, imm};
  endfunction

  function automatic logic [15:0] pfx(input logic [12:0] v);
    return {3'b111, v};
  endfunction

  task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
    nchecks++;
    if (got !== exp) begin
      nerrs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one instruction for one clock edge; the read side is sampled before the edge, the write side after it
  task automatic issue(input logic [15:0] w, input logic vld, input logic ds, input logic [7:0] rdata);
    @(negedge clk);
    insn_i = w; insn_valid_i = vld; delay_slot_i = ds; mem_rdata_i = rdata;
    #1;
    s_addr = mem_addr_o;
    s_rd = mem_rd_o;
    @(posedge clk);
    #1;
    s_we = rf_we_o; s_idx = rf_idx_o; s_wdata = rf_wdata_o;
    insn_valid_i = 1'b0; delay_slot_i = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R11 we after reset", {23'b0, rf_we_o}, 24'd0);
    check("R11 rd after reset", {23'b0, mem_rd_o}, 24'd0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_plain;
    issue(ld(3'd3, 7'h55), 1'b1, 1'b0, 8'h80);
    check("R1 read strobe", {23'b0, s_rd}, 24'd1);
    check("R2 short address", s_addr, 24'h000055);
    check("R12 write enable", {23'b0, s_we}, 24'd1);
    check("R12 index", {21'b0, s_idx}, 24'd3);
    check("R3 negative byte", s_wdata, 24'h00FF80);
    issue(ld(3'd6, 7'h7F), 1'b1, 1'b0, 8'h7F);
    check("R2 short address max", s_addr, 24'h00007F);
    check("R3 positive byte", s_wdata, 24'h00007F);
    check("R12 index 6", {21'b0, s_idx}, 24'd6);
  endtask

  task automatic t_one;
    issue(pfx(13'h1), 1'b1, 1'b0, 8'h00);
    check("R8 prefix no read", {23'b0, s_rd}, 24'd0);
    check("R8 prefix no write", {23'b0, s_we}, 24'd0);
    issue(ld(3'd0, 7'h01), 1'b1, 1'b0, 8'hC3);
    check("R4 example 0x81", s_addr, 24'h000081);
    check("R3 data", s_wdata, 24'h00FFC3);
    issue(pfx(13'h1FFF), 1'b1, 1'b0, 8'h00);
    issue(ld(3'd1, 7'h7F), 1'b1, 1'b0, 8'h00);
    check("R4 all ones", s_addr, 24'h0FFFFF);
    issue(ld(3'd1, 7'h22), 1'b1, 1'b0, 8'h00);
    check("R4 prefix consumed", s_addr, 24'h000022);
  endtask

  task automatic t_two;
    logic [12:0] p1 = 13'h1ABC;
    logic [12:0] p2 = 13'h0123;
    issue(pfx(p1), 1'b1, 1'b0, 8'h00);
    issue(pfx(p2), 1'b1, 1'b0, 8'h00);
    check("R8 second prefix no read", {23'b0, s_rd}, 24'd0);
    issue(ld(3'd5, 7'h7F), 1'b1, 1'b0, 8'h01);
    check("R5 two prefixes bit6 set", s_addr, {p1[4:0], p2, 6'h3F});
    check("R12 index 5", {21'b0, s_idx}, 24'd5);
    issue(pfx(p2), 1'b1, 1'b0, 8'h00);
    issue(pfx(p1), 1'b1, 1'b0, 8'h00);
    issue(ld(3'd2, 7'h15), 1'b1, 1'b0, 8'h00);
    check("R5 two prefixes bit6 clear", s_addr, {p2[4:0], p1, 6'h15});
  endtask

  task automatic t_three;
    issue(pfx(13'h0AAA), 1'b1, 1'b0, 8'h00);
    issue(pfx(13'h1555), 1'b1, 1'b0, 8'h00);
    issue(pfx(13'h0F0F), 1'b1, 1'b0, 8'h00);
    issue(ld(3'd4, 7'h2A), 1'b1, 1'b0, 8'h00);
    check("R6 three prefixes", s_addr, {5'h15, 13'h0F0F, 6'h2A});
  endtask

  task automatic t_delay;
    issue(pfx(13'h0777), 1'b1, 1'b0, 8'h00);
    issue(pfx(13'h1111), 1'b1, 1'b0, 8'h00);
    issue(ld(3'd7, 7'h50), 1'b1, 1'b1, 8'h90);
    check("R7 delay slot short form", s_addr, 24'h000050);
    check("R7 delay slot write", s_wdata, 24'h00FF90);
    issue(ld(3'd7, 7'h20), 1'b1, 1'b0, 8'h00);
    check("R7 prefixes discarded", s_addr, 24'h000020);
  endtask

  task automatic t_other;
    issue(pfx(13'h0003), 1'b1, 1'b0, 8'h00);
    issue(16'h0000, 1'b1, 1'b0, 8'h55);
    check("R9 other no read", {23'b0, s_rd}, 24'd0);
    check("R9 other no write", {23'b0, s_we}, 24'd0);
    issue(16'hC400, 1'b1, 1'b0, 8'h55);
    check("R9 near-load code no read", {23'b0, s_rd}, 24'd0);
    issue(ld(3'd1, 7'h01), 1'b1, 1'b0, 8'h00);
    check("R9 prefix discarded", s_addr, 24'h000001);
  endtask

  task automatic t_gap;
    issue(pfx(13'h0002), 1'b1, 1'b0, 8'h00);
    issue(ld(3'd2, 7'h11), 1'b0, 1'b0, 8'h00);
    check("R10 invalid no read", {23'b0, s_rd}, 24'd0);
    check("R10 invalid no write", {23'b0, s_we}, 24'd0);
    issue(16'h0000, 1'b0, 1'b0, 8'h00);
    issue(ld(3'd2, 7'h11), 1'b1, 1'b0, 8'h00);
    check("R10 prefix held", s_addr, 24'h000111);
  endtask

  task automatic t_reset_mid;
    issue(pfx(13'h0ABC), 1'b1, 1'b0, 8'h00);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    issue(ld(3'd0, 7'h33), 1'b1, 1'b0, 8'h00);
    check("R11 prefix cleared by reset", s_addr, 24'h000033);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchecks++; nerrs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_plain();
    t_one();
    t_two();
    t_three();
    t_delay();
    t_other();
    t_gap();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
      $finish;
    end
  end
endmodule